// File: doc/BRIEF.md
# Peripheral Chip-Select Decoder with Wait States

This block watches the address of each bus cycle and drives one of six active-low peripheral selects when the address falls inside a programmable 2 KB window. The window is split into eight 256-byte slices. Slice index `k`, taken from address bits [10:8], drives select `k`. Slice 4 has no select. The window can be placed in the 1 MB memory space or in the 64 KB I/O space, and only cycles of the matching type are decoded. Each select has its own 3-bit wait code. The block counts out that many wait states, raises `ready` when the count is done, and reports the count on `wait_cnt`.

Software writes the window base and space with `base_we`, and writes wait codes one select at a time with `ws_we`. No select can fire until the base has been written once after reset. All pins are plain control signals: there is no data stream and no back-pressure. A `cyc_start` pulse that arrives while a cycle is running is dropped, and the caller must not start a new cycle before it sees `ready`. The window must be placed so that it does not overlap the regions of the other chip-select units. This is a placement rule for software and the block does not check it.

Top module: `pcs_unit`

## Requirements
- R1: Six selects exist, at indices 0, 1, 2, 3, 5 and 6. A decoded cycle with slice index k = addr[10:8] drives `pcs_n[k]` low and leaves every other bit high. Slice 4 and index 7 never assert a select and give no `ready`.
- R2: After reset, `pcs_n` is all ones, `ready` is 0, `wait_cnt` is 0 and every wait code is 0. No select asserts until `base_we` has been written once.
- R3: In memory mode (`base_io`=0 when written), a cycle with `io_cycle`=0 hits only when addr[19:11] equals the 9-bit base.
- R4: In I/O mode (`base_io`=1 when written), a cycle with `io_cycle`=1 hits when addr[15:11] equals base bits [4:0]. Address bits [19:16] are ignored.
- R5: A cycle whose `io_cycle` value differs from the programmed space never asserts a select.
- R6: Let W be the select's wait count and T the clock edge that samples `cyc_start`=1 on a hit. The select goes low after edge T and stays low for exactly W+1 cycles. `ready` is 1 only in the last of those cycles. The select is released on the following edge.
- R7: Wait codes 0 to 3 give W = 0 to 3 on every select.
- R8: On selects 0 to 3, wait codes 4, 5, 6 and 7 give W = 5, 7, 9 and 15.
- R9: On selects 5 and 6, wait codes 4 to 7 saturate to W = 3.
- R10: `wait_cnt` shows W while a select is low and 0 otherwise.
- R11: A `cyc_start` pulse that arrives while a cycle is in progress is ignored. The running select, its length and `wait_cnt` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 20 | Address of the cycle, valid when `cyc_start` is 1 |
| io_cycle | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| cyc_start | input | 1 | One-cycle strobe that starts a bus cycle |
| base_we | input | 1 | Write strobe for the base and space; arms the block |
| base_val | input | 9 | Window base, in 2 KB units |
| base_io | input | 1 | Space select written with the base (1 = I/O) |
| ws_we | input | 1 | Write strobe for one wait code |
| ws_idx | input | 3 | Index of the select whose wait code is written |
| ws_code | input | 3 | Wait code |
| pcs_n | output | 8 | Active-low selects, bit k for slice k |
| ready | output | 1 | High in the last cycle of a decoded bus cycle |
| wait_cnt | output | 4 | Wait states inserted for the active select |

## Verification
Every wait code from 0 to 7 is loaded on all selects and driven through every slice. This separates the linear codes, the extended codes and the saturation on the upper selects, and shows that slice 4 stays silent. A second pattern gives each select a different code at the same time, which catches a wait value taken from the wrong index. Addresses one window above the base, I/O-mode addresses with junk in the upper bits, and cycles of the wrong space tell the base compare apart from the space check. A start pulse injected during a long cycle shows that a running cycle cannot be restarted.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int CODE_W = 3;
  localparam int WAIT_W = 4;

  // Map a wait code to a wait count; ext_ok enables the non-linear upper codes.
  function automatic logic [WAIT_W-1:0] ws_map(input logic [CODE_W-1:0] code,
                                               input logic ext_ok);
    logic [WAIT_W-1:0] w;
    if (!code[2]) w = {2'b00, code[1:0]};
    else if (!ext_ok) w = 4'd3;
    else begin
      case (code[1:0])
        2'd0:    w = 4'd5;
        2'd1:    w = 4'd7;
        2'd2:    w = 4'd9;
        default: w = 4'd15;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/pcs_cfg.sv
module pcs_cfg
  import pcs_pkg::*;
#(
  parameter int BASE_W    = 9,
  parameter int SEL_BITS  = 3,
  parameter int HOLE      = 4,
  parameter int EXT_SLOTS = 4,
  parameter int LIVE_MAX  = 6,
  localparam int NSLOT    = 1 << SEL_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    base_we,
  input  logic [BASE_W-1:0]       base_val,
  input  logic                    base_io,
  input  logic                    ws_we,
  input  logic [SEL_BITS-1:0]     ws_idx,
  input  logic [CODE_W-1:0]       ws_code,
  output logic [BASE_W-1:0]       base_q,
  output logic                    io_q,
  output logic                    armed,
  output logic [NSLOT*WAIT_W-1:0] wait_tab
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      io_q   <= 1'b0;
      armed  <= 1'b0;
    end else if (base_we) begin
      base_q <= base_val;
      io_q   <= base_io;
      armed  <= 1'b1;
    end
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (k == HOLE || k > LIVE_MAX) begin : g_absent
      assign wait_tab[k*WAIT_W +: WAIT_W] = '0;
    end else begin : g_live
      logic [CODE_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else if (ws_we && ws_idx == SEL_BITS'(k)) code_q <= ws_code;
      end
      assign wait_tab[k*WAIT_W +: WAIT_W] = ws_map(code_q, k < EXT_SLOTS);
    end
  end

  // R2: the block stays disarmed until the base is written.
  a_r2_arm_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !base_we) |=> !armed);
endmodule

// File: rtl/pcs_match.sv
module pcs_match #(
  parameter int ADDR_W   = 20,
  parameter int IO_W     = 16,
  parameter int SLICE_LSB = 8,
  parameter int SEL_BITS = 3,
  parameter int HOLE     = 4,
  parameter int LIVE_MAX = 6,
  localparam int NSLOT   = 1 << SEL_BITS,
  localparam int BLK_LSB = SLICE_LSB + SEL_BITS,
  localparam int BASE_W  = ADDR_W - BLK_LSB,
  localparam int IOB_W   = IO_W - BLK_LSB
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                io_cycle,
  input  logic                armed,
  input  logic [BASE_W-1:0]   base_q,
  input  logic                io_q,
  output logic                hit,
  output logic [SEL_BITS-1:0] slice,
  output logic [NSLOT-1:0]    sel_oh
);
  logic in_win;

  assign slice = addr[BLK_LSB-1:SLICE_LSB];

  always_comb begin
    if (io_q) in_win = addr[IO_W-1:BLK_LSB] == base_q[IOB_W-1:0];
    else      in_win = addr[ADDR_W-1:BLK_LSB] == base_q;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_oh
    if (k == HOLE || k > LIVE_MAX) begin : g_none
      assign sel_oh[k] = 1'b0;
    end else begin : g_sel
      assign sel_oh[k] = slice == SEL_BITS'(k);
    end
  end

  assign hit = armed && (io_cycle == io_q) && in_win && (|sel_oh);
endmodule

// File: rtl/pcs_timer.sv
module pcs_timer
  import pcs_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NSLOT-1:0]  sel_oh,
  input  logic [WAIT_W-1:0] wait_val,
  output logic [NSLOT-1:0]  pcs_n,
  output logic              ready,
  output logic [WAIT_W-1:0] wait_cnt,
  output logic              busy
);
  logic [NSLOT-1:0]  sel_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] wq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sel_q <= '0;
      cnt_q <= '0;
      wq    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        sel_q <= sel_oh;
        cnt_q <= wait_val;
        wq    <= wait_val;
      end
    end else if (cnt_q == '0) begin
      busy  <= 1'b0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pcs_n    = ~sel_q;
  assign ready    = busy && (cnt_q == '0);
  assign wait_cnt = busy ? wq : '0;

  // R1: at most one select low at a time.
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~pcs_n));
  // R6: the select is released right after ready.
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (&pcs_n));
  // R6: the select is held steady until ready.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready) |=> ($stable(pcs_n) && !(&pcs_n)));
  // R11: the wait count of a running cycle does not change.
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready) |=> $stable(wait_cnt));
  // R10: no wait count is shown while idle.
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (&pcs_n) |-> (wait_cnt == '0));
endmodule

// File: rtl/pcs_unit.sv
module pcs_unit
  import pcs_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int IO_W      = 16,
  parameter int SLICE_LSB = 8,
  parameter int SEL_BITS  = 3,
  parameter int HOLE      = 4,
  parameter int EXT_SLOTS = 4,
  parameter int LIVE_MAX  = 6,
  localparam int NSLOT    = 1 << SEL_BITS,
  localparam int BASE_W   = ADDR_W - SLICE_LSB - SEL_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                io_cycle,
  input  logic                cyc_start,
  input  logic                base_we,
  input  logic [BASE_W-1:0]   base_val,
  input  logic                base_io,
  input  logic                ws_we,
  input  logic [SEL_BITS-1:0] ws_idx,
  input  logic [CODE_W-1:0]   ws_code,
  output logic [NSLOT-1:0]    pcs_n,
  output logic                ready,
  output logic [WAIT_W-1:0]   wait_cnt
);
  logic [BASE_W-1:0]       base_q;
  logic                    io_q;
  logic                    armed;
  logic [NSLOT*WAIT_W-1:0] wait_tab;
  logic                    hit;
  logic [SEL_BITS-1:0]     slice;
  logic [NSLOT-1:0]        sel_oh;
  logic                    busy;
  logic                    start;

  pcs_cfg #(.BASE_W(BASE_W), .SEL_BITS(SEL_BITS), .HOLE(HOLE),
            .EXT_SLOTS(EXT_SLOTS), .LIVE_MAX(LIVE_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_val(base_val),
    .base_io(base_io), .ws_we(ws_we), .ws_idx(ws_idx), .ws_code(ws_code),
    .base_q(base_q), .io_q(io_q), .armed(armed), .wait_tab(wait_tab));

  pcs_match #(.ADDR_W(ADDR_W), .IO_W(IO_W), .SLICE_LSB(SLICE_LSB),
              .SEL_BITS(SEL_BITS), .HOLE(HOLE), .LIVE_MAX(LIVE_MAX)) u_match (
    .addr(addr), .io_cycle(io_cycle), .armed(armed), .base_q(base_q),
    .io_q(io_q), .hit(hit), .slice(slice), .sel_oh(sel_oh));

  assign start = cyc_start && hit;

  pcs_timer #(.NSLOT(NSLOT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_oh(sel_oh),
    .wait_val(wait_tab[slice*WAIT_W +: WAIT_W]), .pcs_n(pcs_n),
    .ready(ready), .wait_cnt(wait_cnt), .busy(busy));

  // R1: the missing slice never drives its select.
  a_r1_hole_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_n[HOLE]);
  // R2: nothing asserts before the block is armed.
  a_r2_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> ((&pcs_n) && !ready));
  // R6: an accepted hit drives a select on the next cycle.
  a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && hit && !busy) |=> !(&pcs_n));
  // R5: a cycle of the wrong space never starts a select.
  a_r5_space: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && (io_cycle != io_q) && !busy) |=> (&pcs_n));
endmodule

// File: tb/pcs_unit_test.sv
module pcs_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        io_cycle = 1'b0;
  logic        cyc_start = 1'b0;
  logic        base_we = 1'b0;
  logic [8:0]  base_val = '0;
  logic        base_io = 1'b0;
  logic        ws_we = 1'b0;
  logic [2:0]  ws_idx = '0;
  logic [2:0]  ws_code = '0;
  logic [7:0]  pcs_n;
  logic        ready;
  logic [3:0]  wait_cnt;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pcs_unit uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .io_cycle(io_cycle),
    .cyc_start(cyc_start), .base_we(base_we), .base_val(base_val),
    .base_io(base_io), .ws_we(ws_we), .ws_idx(ws_idx), .ws_code(ws_code),
    .pcs_n(pcs_n), .ready(ready), .wait_cnt(wait_cnt));

  function automatic int wexp(input int idx, input int code);
    int ext [4] = '{5, 7, 9, 15};
    if (code < 4) return code;
    if (idx >= 5) return 3;
    return ext[code-4];
  endfunction

  task automatic set_base(input logic [8:0] b, input logic io);
    @(negedge clk);
    base_val = b; base_io = io; base_we = 1'b1;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic set_ws(input int idx, input int code);
    @(negedge clk);
    ws_idx = 3'(idx); ws_code = 3'(code); ws_we = 1'b1;
    @(negedge clk);
    ws_we = 1'b0;
  endtask

  task automatic bus_cycle(input logic [19:0] a, input logic io, input int exp_idx,
                           input int exp_w, input string tag, input bit poke);
    logic [7:0] ev;
    logic [7:0] fp; logic fr; logic [3:0] fw;
    logic [7:0] fep; logic fer; int few; int fs;
    bit err = 1'b0;
    @(negedge clk);
    addr = a; io_cycle = io; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    for (int s = 1; s <= 20; s++) begin
      bit act;
      act = (exp_idx >= 0) && (s <= exp_w + 1);
      ev = 8'hFF;
      if (act) ev[exp_idx] = 1'b0;
      if (!err && (pcs_n !== ev || ready !== (act && s == exp_w + 1) ||
                   wait_cnt !== (act ? 4'(exp_w) : 4'd0))) begin
        err = 1'b1; fs = s; fp = pcs_n; fr = ready; fw = wait_cnt;
        fep = ev; fer = act && (s == exp_w + 1); few = act ? exp_w : 0;
      end
      if (poke && s == 2) begin
        addr = a ^ 20'h00100; cyc_start = 1'b1;
      end else if (poke && s == 3) begin
        cyc_start = 1'b0; addr = a;
      end
      @(negedge clk);
    end
    total++;
    if (err) begin
      bad++;
      $display("FAIL %s addr=%h io=%b sample %0d: pcs_n=%h ready=%b wait=%0d expected pcs_n=%h ready=%b wait=%0d",
               tag, a, io, fs, fp, fr, fw, fep, fer, few);
    end
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [19:0] mb;
    repeat (3) @(negedge clk);
    total++;
    if (pcs_n !== 8'hFF || ready !== 1'b0 || wait_cnt !== 4'd0) begin
      bad++;
      $display("FAIL R2 reset: pcs_n=%h ready=%b wait=%0d expected pcs_n=ff ready=0 wait=0",
               pcs_n, ready, wait_cnt);
    end
    rst_n = 1'b1;
    // R2: unarmed, the base-0 window must stay silent.
    bus_cycle(20'h00100, 1'b0, -1, 0, "R2 unarmed", 1'b0);

    // R3 memory window at 0xA5 * 2 KB.
    set_base(9'h0A5, 1'b0);
    mb = 20'(9'h0A5) << 11;
    // R2: reset wait codes are 0.
    bus_cycle(mb | 20'h300, 1'b0, 3, 0, "R2 R7 reset code", 1'b0);
    // R1 R6 R7 R8 R9 R10: every code on every slice.
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 8; k++) set_ws(k, c);
      for (int k = 0; k < 8; k++)
        bus_cycle(mb | 20'(k << 8) | 20'((k * 37 + c * 11) & 8'hFF), 1'b0,
                  (k == 4 || k == 7) ? -1 : k, wexp(k, c),
                  "R1 R6 R7 R8 R9 R10 sweep", 1'b0);
    end
    // Distinct code per select.
    for (int k = 0; k < 8; k++) set_ws(k, 7 - k);
    for (int k = 0; k < 8; k++)
      bus_cycle(mb | 20'(k << 8), 1'b0, (k == 4 || k == 7) ? -1 : k,
                wexp(k, 7 - k), "R8 R9 per-select code", 1'b0);
    // R3: window edges.
    bus_cycle(mb | 20'h6FF, 1'b0, 6, wexp(6, 1), "R3 top byte", 1'b0);
    bus_cycle(mb + 20'h00800, 1'b0, -1, 0, "R3 next window", 1'b0);
    bus_cycle(mb - 20'h00100, 1'b0, -1, 0, "R3 below window", 1'b0);
    // R5: memory window, I/O cycle.
    bus_cycle(mb | 20'h100, 1'b1, -1, 0, "R5 io on mem", 1'b0);
    // R11: a start pulse during a 15-wait cycle.
    set_ws(2, 7);
    bus_cycle(mb | 20'h200, 1'b0, 2, 15, "R11 restart ignored", 1'b0 | 1'b1);

    // R4 I/O window, base low bits 0x13.
    set_base(9'h1F3, 1'b1);
    for (int k = 0; k < 8; k++)
      bus_cycle(20'hA0000 | 20'(5'h13 << 11) | 20'(k << 8) | 20'h05, 1'b1,
                (k == 4 || k == 7) ? -1 : k, wexp(k, 7 - k) + ((k == 2) ? 15 - wexp(2, 5) : 0),
                "R4 io window", 1'b0);
    bus_cycle(20'(5'h12 << 11) | 20'h100, 1'b1, -1, 0, "R4 io miss", 1'b0);
    bus_cycle(20'(5'h13 << 11) | 20'h100, 1'b0, -1, 0, "R5 mem on io", 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule